// File: doc/BRIEF.md
# Prioritized Channel-Mapped Interrupt Controller

This block collects a set of system interrupt lines and presents them to a processor as two host requests: a fast request and a normal request. Every line has a raw status bit, an enable bit, a polarity bit and a detection-type bit. A line can be programmed to detect edges or levels.

Each line is steered to one of the host channels by a byte-wide field in a channel-map register. Among the lines that are both pending and enabled, the one on the lowest-numbered channel wins. Lines on the lowest channels raise the fast request, and all other lines raise the normal request. The index of each winner is also brought out on ports.

Software reaches the block through a plain register bus with a word address, write data, a write strobe and combinational read data. Enables and status bits are changed one line at a time by writing a line number to an index register, or many at a time through word-wide clear registers.

Top module: `chmap_intc`

## Requirements
- R1: After reset the global enable, both host enables and all line enables are 0, both requests are low, both index ports read all ones (7'h7F), and every channel-map register reads 0x0F0F0F0F.
- R2: The polarity words (0x180 + 4g) and type words (0x1C0 + 4g) hold one bit per line, with line 32g+b at bit b. With type 1 (edge), polarity 1 latches status on a rising input and polarity 0 latches it on a falling input. With type 0 (level), status is set on every cycle the input equals the polarity bit. Reset values are polarity 1 and type 0. The raw status words read at 0x100 + 4g.
- R3: Writing a line number to the status-index-clear register (0x018) clears only that line's status bit. A level line whose input is still active sets its bit again on the same cycle.
- R4: Writing a line number to enable-index-set (0x010) enables only that line, and writing it to enable-index-clear (0x014) disables only that line. A value at or above the line count changes nothing.
- R5: In the status words (0x100 + 4g) and the enable words (0x140 + 4g), a written 1 clears the matching line's bit and a written 0 leaves it unchanged.
- R6: Channel-map register n at 0x200 + 4n covers lines 4n to 4n+3, one byte per line with line 4n+k in bits 8k+7:8k. The channel number sits in the low 5 bits of that byte.
- R7: Among the pending, enabled lines of one host output, the line on the lowest channel number wins. On equal channels the lower line index wins.
- R8: Channels 0 and 1 feed the fast request and index port. Channels 2 to 31 feed the normal request and index port. When no line qualifies, an index port reads all ones.
- R9: A value written to host-index-set (0x008) or host-index-clear (0x00C) sets or clears host enable bit 0 (fast) or bit 1 (normal). The host enable word at 0x004 is readable and writable. Bit 0 of the global enable at 0x000 gates both requests. A request is high only when its winner exists, its host enable is set and the global enable is set.
- R10: The winner register at 0x01C returns the normal winner's line index, or 0xFFFFFFFF when there is no normal winner. It is not affected by the host or global enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | System interrupt lines |
| addr | input | AW | Byte address of the register access |
| wdata | input | 32 | Write data |
| wen | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Combinational read data for addr |
| fast_irq | output | 1 | Fast host request |
| norm_irq | output | 1 | Normal host request |
| fast_idx | output | IW | Fast winner line index, all ones if none |
| norm_idx | output | IW | Normal winner line index, all ones if none |

## Verification
The bench builds the block with its default parameters: 64 lines, 32 channels and two fast channels. These values make the second status and enable word, the top line index 63, the last channel-map register (n = 15) and the one-past-range index 64 all reachable. Beyond that, an index port 7 bits wide keeps the all-ones "no winner" code separate from a real line 63. Directed phases work through edge and level detection of both senses and channel ties. Randomized register writes and input toggles then drive the behavioural model and the design side by side.

// File: rtl/chmap_intc.sv
module chmap_intc #(
  parameter int NUM_LINES  = 64,
  parameter int NUM_CHAN   = 32,
  parameter int FAST_CHANS = 2,
  parameter int DEF_CHAN   = 15,
  parameter int AW         = 10,
  localparam int IW        = $clog2(NUM_LINES) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [AW-1:0]        addr,
  input  logic [31:0]          wdata,
  input  logic                 wen,
  output logic [31:0]          rdata,
  output logic                 fast_irq,
  output logic                 norm_irq,
  output logic [IW-1:0]        fast_idx,
  output logic [IW-1:0]        norm_idx
);
  localparam int LIW    = $clog2(NUM_LINES);
  localparam int CW     = $clog2(NUM_CHAN);
  localparam int W_GEN  = 0;
  localparam int W_HEN  = 1;
  localparam int W_HSET = 2;
  localparam int W_HCLR = 3;
  localparam int W_ESET = 4;
  localparam int W_ECLR = 5;
  localparam int W_SCLR = 6;
  localparam int W_WIN  = 7;
  localparam int W_STAT = 'h40;
  localparam int W_ENW  = 'h50;
  localparam int W_POL  = 'h60;
  localparam int W_TYP  = 'h70;
  localparam int W_MAP  = 'h80;

  logic [NUM_LINES-1:0] stat, en, pol, typ, prv;
  logic [NUM_LINES-1:0] det, s_clr, e_clr, e_set, pend;
  logic [CW-1:0]        chan [NUM_LINES];
  logic                 gen;
  logic [1:0]           hen;
  logic [31:0]          wi;
  logic                 ffound, nfound;
  logic [LIW-1:0]       fwin, nwin;
  logic [CW-1:0]        fch, nch;

  assign wi   = 32'(addr[AW-1:2]);
  assign pend = stat & en;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      det[i]   = typ[i] ? (pol[i] ? (irq_in[i] & ~prv[i]) : (~irq_in[i] & prv[i]))
                        : (irq_in[i] == pol[i]);
      s_clr[i] = wen && ((wi == W_SCLR && wdata == 32'(i)) ||
                         (wi == 32'(W_STAT + i / 32) && wdata[i % 32]));
      e_clr[i] = wen && ((wi == W_ECLR && wdata == 32'(i)) ||
                         (wi == 32'(W_ENW + i / 32) && wdata[i % 32]));
      e_set[i] = wen && wi == W_ESET && wdata == 32'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
      pol  <= '1;
      typ  <= '0;
      prv  <= '0;
      gen  <= 1'b0;
      hen  <= 2'b00;
      for (int i = 0; i < NUM_LINES; i++) chan[i] <= CW'(DEF_CHAN);
    end else begin
      prv  <= irq_in;
      stat <= (stat & ~s_clr) | det;
      en   <= (en & ~e_clr) | e_set;
      if (wen) begin
        if (wi == W_GEN) gen <= wdata[0];
        if (wi == W_HEN) hen <= wdata[1:0];
        if (wi == W_HSET && wdata < 32'd2) hen[wdata[0]] <= 1'b1;
        if (wi == W_HCLR && wdata < 32'd2) hen[wdata[0]] <= 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
          if (wi == 32'(W_POL + i / 32)) pol[i] <= wdata[i % 32];
          if (wi == 32'(W_TYP + i / 32)) typ[i] <= wdata[i % 32];
          if (wi == 32'(W_MAP + i / 4))  chan[i] <= wdata[(i % 4) * 8 +: CW];
        end
      end
    end
  end

  always_comb begin
    ffound = 1'b0; nfound = 1'b0;
    fwin = '0; nwin = '0; fch = '0; nch = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        if (32'(chan[i]) < FAST_CHANS) begin
          if (!ffound || chan[i] <= fch) begin
            ffound = 1'b1; fch = chan[i]; fwin = LIW'(i);
          end
        end else if (!nfound || chan[i] <= nch) begin
          nfound = 1'b1; nch = chan[i]; nwin = LIW'(i);
        end
      end
    end
  end

  assign fast_idx = ffound ? {1'b0, fwin} : '1;
  assign norm_idx = nfound ? {1'b0, nwin} : '1;
  assign fast_irq = gen & hen[0] & ffound;
  assign norm_irq = gen & hen[1] & nfound;

  always_comb begin
    rdata = '0;
    if (wi == W_GEN) rdata[0] = gen;
    if (wi == W_HEN) rdata[1:0] = hen;
    if (wi == W_WIN) rdata = nfound ? 32'(nwin) : '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (wi == 32'(W_STAT + i / 32)) rdata[i % 32] = stat[i];
      if (wi == 32'(W_ENW + i / 32))  rdata[i % 32] = en[i];
      if (wi == 32'(W_POL + i / 32))  rdata[i % 32] = pol[i];
      if (wi == 32'(W_TYP + i / 32))  rdata[i % 32] = typ[i];
      if (wi == 32'(W_MAP + i / 4))   rdata[(i % 4) * 8 +: CW] = chan[i];
    end
  end

  p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && wi == W_ESET && wdata < 32'(NUM_LINES)) |=> en[$past(wdata[LIW-1:0])]);

  p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && wi == W_ECLR && wdata < 32'(NUM_LINES)) |=> !en[$past(wdata[LIW-1:0])]);

  p_stat_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && wi == W_SCLR && wdata < 32'(NUM_LINES) && !typ[wdata[LIW-1:0]] &&
     irq_in[wdata[LIW-1:0]] != pol[wdata[LIW-1:0]]) |=> !stat[$past(wdata[LIW-1:0])]);

  p_fast_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_idx[IW-1] |-> (stat[fast_idx[LIW-1:0]] && en[fast_idx[LIW-1:0]] &&
                         32'(chan[fast_idx[LIW-1:0]]) < FAST_CHANS));

  p_norm_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_idx[IW-1] |-> (stat[norm_idx[LIW-1:0]] && en[norm_idx[LIW-1:0]] &&
                         32'(chan[norm_idx[LIW-1:0]]) >= FAST_CHANS));
endmodule

// File: tb/chmap_intc_tb.sv
module chmap_intc_tb;
  localparam int N  = 64;
  localparam int IW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic [9:0]    addr = 10'h01C;
  logic [31:0]   wdata = '0;
  logic          wen = 1'b0;
  logic [31:0]   rdata;
  logic          fast_irq, norm_irq;
  logic [IW-1:0] fast_idx, norm_idx;

  chmap_intc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .wdata(wdata),
    .wen(wen), .rdata(rdata), .fast_irq(fast_irq), .norm_irq(norm_irq),
    .fast_idx(fast_idx), .norm_idx(norm_idx)
  );

  always #10 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  bit [N-1:0] m_stat, m_en, m_pol, m_typ, m_prv;
  int         m_ch [N];
  bit         m_gen;
  bit [1:0]   m_hen;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_stat = '0; m_en = '0; m_pol = '1; m_typ = '0; m_prv = '0;
    m_gen = 0; m_hen = 0;
    for (int i = 0; i < N; i++) m_ch[i] = 15;
  endfunction

  function automatic int m_winner(bit fast);
    for (int c = 0; c < 32; c++)
      if ((c < 2) == fast)
        for (int l = 0; l < N; l++)
          if (m_stat[l] && m_en[l] && m_ch[l] == c) return l;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(logic [9:0] a);
    int w = int'(a) / 4;
    logic [31:0] r = '0;
    int nw;
    if (w == 0) r[0] = m_gen;
    else if (w == 1) r[1:0] = m_hen;
    else if (w == 7) begin
      nw = m_winner(0);
      r = (nw < 0) ? 32'hFFFF_FFFF : 32'(nw);
    end else if (w >= 'h40 && w < 'h42) r = m_stat[(w - 'h40) * 32 +: 32];
    else if (w >= 'h50 && w < 'h52) r = m_en[(w - 'h50) * 32 +: 32];
    else if (w >= 'h60 && w < 'h62) r = m_pol[(w - 'h60) * 32 +: 32];
    else if (w >= 'h70 && w < 'h72) r = m_typ[(w - 'h70) * 32 +: 32];
    else if (w >= 'h80 && w < 'h90)
      for (int k = 0; k < 4; k++) r[8 * k +: 8] = 8'(m_ch[(w - 'h80) * 4 + k]);
    return r;
  endfunction

  function automatic void m_step();
    bit [N-1:0] d;
    int w = int'(addr) / 4;
    int v;
    for (int i = 0; i < N; i++)
      d[i] = m_typ[i] ? (m_pol[i] ? (irq_in[i] && !m_prv[i]) : (!irq_in[i] && m_prv[i]))
                      : (irq_in[i] == m_pol[i]);
    if (wen) begin
      v = int'(wdata);
      if (w == 0) m_gen = wdata[0];
      if (w == 1) m_hen = wdata[1:0];
      if (w == 2 && wdata < 2) m_hen[v] = 1;
      if (w == 3 && wdata < 2) m_hen[v] = 0;
      if (w == 4 && wdata < N) m_en[v] = 1;
      if (w == 5 && wdata < N) m_en[v] = 0;
      if (w == 6 && wdata < N) m_stat[v] = 0;
      if (w >= 'h40 && w < 'h42) m_stat[(w - 'h40) * 32 +: 32] &= ~wdata;
      if (w >= 'h50 && w < 'h52) m_en[(w - 'h50) * 32 +: 32] &= ~wdata;
      if (w >= 'h60 && w < 'h62) m_pol[(w - 'h60) * 32 +: 32] = wdata;
      if (w >= 'h70 && w < 'h72) m_typ[(w - 'h70) * 32 +: 32] = wdata;
      if (w >= 'h80 && w < 'h90)
        for (int k = 0; k < 4; k++) m_ch[(w - 'h80) * 4 + k] = int'(wdata[8 * k +: 5]);
    end
    m_stat |= d;
    m_prv = irq_in;
  endfunction

  task automatic compare_all();
    int f = m_winner(1);
    int n = m_winner(0);
    logic [IW-1:0] ef = (f < 0) ? '1 : IW'(f);
    logic [IW-1:0] en_ = (n < 0) ? '1 : IW'(n);
    chk("fast_idx", 32'(fast_idx), 32'(ef));
    chk("norm_idx", 32'(norm_idx), 32'(en_));
    chk("fast_irq", 32'(fast_irq), 32'(m_gen && m_hen[0] && f >= 0));
    chk("norm_irq", 32'(norm_irq), 32'(m_gen && m_hen[1] && n >= 0));
    chk($sformatf("rdata@%h", addr), rdata, m_read(addr));
  endtask

  task automatic tick();
    m_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
    tick();
    wen = 1'b0; addr = 10'h01C;
  endtask

  task automatic rd(logic [9:0] a);
    addr = a;
    tick();
    addr = 10'h01C;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    compare_all();
    rd(10'h200); rd(10'h23C); rd(10'h000); rd(10'h004); rd(10'h140);
    chk("R1 map default", m_read(10'h204), 32'h0F0F0F0F);

    cur_req = "R9";
    wr(10'h008, 1); wr(10'h008, 0); wr(10'h000, 1); rd(10'h004);

    cur_req = "R4";
    wr(10'h010, 5); wr(10'h010, 40); wr(10'h010, 63); wr(10'h010, 64); wr(10'h010, 200);
    rd(10'h140); rd(10'h144);

    cur_req = "R2";
    irq_in[5] = 1'b1; tick(); tick();
    rd(10'h100);
    wr(10'h1C4, 32'h0000_0100);
    wr(10'h184, 32'hFFFF_FEFF);
    irq_in[40] = 1'b1; tick(); tick();
    irq_in[40] = 1'b0; tick(); tick(); rd(10'h104);

    cur_req = "R3";
    wr(10'h018, 40); rd(10'h104);
    wr(10'h018, 5);  rd(10'h100);
    irq_in[5] = 1'b0; wr(10'h018, 5); rd(10'h100);

    cur_req = "R6";
    wr(10'h200, 32'h0203_0405); rd(10'h200);
    wr(10'h23C, 32'h1F01_0000); rd(10'h23C);

    cur_req = "R7";
    wr(10'h010, 0); wr(10'h010, 1); wr(10'h010, 2); wr(10'h010, 3);
    irq_in[3:0] = 4'hF; tick(); tick();
    wr(10'h200, 32'h0505_0505); tick();
    wr(10'h200, 32'h0304_0506); tick();

    cur_req = "R8";
    irq_in[63] = 1'b1; tick(); tick();
    wr(10'h23C, 32'h0000_0000); tick();

    cur_req = "R5";
    wr(10'h144, 32'h8000_0000); rd(10'h144);
    wr(10'h100, 32'h0000_000F); rd(10'h100);
    wr(10'h104, 32'hFFFF_FFFF); rd(10'h104);

    cur_req = "R9";
    wr(10'h00C, 1); tick(); wr(10'h000, 0); tick(); wr(10'h000, 1); wr(10'h004, 3); tick();

    cur_req = "R10";
    irq_in = '0;
    wr(10'h050, 32'hFFFF_FFFF); wr(10'h054, 32'hFFFF_FFFF);
    wr(10'h1C0, 32'hFFFF_FFFF); wr(10'h1C4, 32'hFFFF_FFFF);
    rd(10'h01C); rd(10'h100);

    cur_req = "R7";
    for (int t = 0; t < 4000; t++) begin
      int sel;
      if ($urandom_range(3) == 0) irq_in[$urandom_range(N - 1)] ^= 1'b1;
      if ($urandom_range(3) == 0) begin
        sel = $urandom_range(9);
        case (sel)
          0: wr(10'h010, $urandom_range(70));
          1: wr(10'h014, $urandom_range(70));
          2: wr(10'h018, $urandom_range(70));
          3: wr(10'(10'h180 + 4 * $urandom_range(1)), $urandom);
          4: wr(10'(10'h1C0 + 4 * $urandom_range(1)), $urandom);
          5: wr(10'(10'h200 + 4 * $urandom_range(15)), $urandom & 32'h1F1F1F1F);
          6: wr(10'(10'h100 + 4 * $urandom_range(1)), $urandom);
          7: wr(10'(10'h008 + 4 * $urandom_range(1)), $urandom_range(3));
          8: wr(10'h000, ($urandom_range(7) != 0) ? 1 : 0);
          default: rd(10'(4 * $urandom_range(7)));
        endcase
      end else begin
        tick();
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule